// File: doc/BRIEF.md
# MMU Control Register File

This block is a bank of nine 32-bit control registers that sits between a register bus and a memory-management and exception unit. It holds the MMU control word, the page-table entry high, low and assist words, the translation table base, the faulting address, the trap code, and the exception and interrupt event codes. Each stored value passes through a per-register keep mask.

Some writes also produce single-cycle strobes toward a translation buffer. A control write that carries the invalidate bit raises an invalidate-all strobe, and that bit is never kept. A write to the entry-high word raises a flush strobe only when it changes the address-space identifier held in the low byte. The translation buffer and the exception logic are outside this block.

Accesses must be 32 bits wide and word aligned, and must fall on a mapped offset. Any other access sets a sticky error flag and has no effect on the registers. Reads answer one cycle after the request.

Top module: `mmu_ctrl_regfile`

## Requirements
- R1: A valid word write to the control word (offset 0x00) with data bit 2 set drives `tlb_inval_pulse` high for exactly the cycle after the request. With bit 2 clear, no pulse is issued.
- R2: Bit 2 of the control word is never stored and always reads as 0. The other 31 bits of the control word are stored as written.
- R3: A valid word write to the entry-high word (offset 0x04) drives `tlb_flush_pulse` high in the cycle after the request only when data bits [7:0] differ from the bits [7:0] held before the write. All 32 bits are stored either way.
- R4: The assist word (offset 0x0C) keeps only data bits [3:0]. Its upper bits read as 0.
- R5: The trap code (0x18), exception event (0x1C) and interrupt event (0x20) words keep only bits [10:0].
- R6: The entry-low (0x08), table base (0x10) and fault address (0x14) words store all 32 bits unchanged.
- R7: A read request returns its data on `rsp_rdata`, with `rsp_valid` high, in the cycle after the request. Writes never raise `rsp_valid`.
- R8: An access is bad when `req_size` is not 2'b10 (2'b00 byte, 2'b01 half, 2'b10 word), when the offset is not a multiple of 4, or when the offset is 0x24 or above. A bad access sets `err_flag`, which stays set until reset. A bad read returns 0. A bad write changes no register and issues no strobe.
- R9: After reset every register reads 0, `err_flag` is 0, and neither strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request for this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the bank |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| err_flag | output | 1 | Sticky bad-access flag |
| tlb_inval_pulse | output | 1 | Invalidate-all strobe |
| tlb_flush_pulse | output | 1 | Flush strobe on identifier change |

## Verification
Every mapped register is written with a sequence of data patterns, and each write is read back. The sequence covers all ones, all zeros, alternating bit patterns, and a word with only bit 2 set. The all-ones and alternating patterns show whether each keep mask is too wide or too narrow, and the bit-2-only word isolates the invalidate strobe from the stored value. The sequence also includes two consecutive entry-high writes that share a low byte but differ above it; this separates a flush decided on the identifier from one decided on the whole word. Bad accesses of each kind (unmapped offset, misaligned offset, narrow size) are followed by readback of every register and by a check of both strobes, which shows that nothing changed.

// File: rtl/mrf_pkg.sv
// Shared constants for the MMU control register file: register indices,
// field positions and the per-register keep masks.
package mrf_pkg;
    localparam int DW        = 32;
    localparam int NREG      = 9;
    localparam int ASID_W    = 8;
    localparam int INVAL_BIT = 2;

    localparam int IDX_CTRL  = 0;
    localparam int IDX_PGHI  = 1;
    localparam int IDX_PGLO  = 2;
    localparam int IDX_PGAS  = 3;
    localparam int IDX_TBASE = 4;
    localparam int IDX_FADDR = 5;
    localparam int IDX_TRAP  = 6;
    localparam int IDX_EXEV  = 7;
    localparam int IDX_INEV  = 8;

    localparam logic [1:0] SZ_WORD = 2'b10;

    // Bits each register keeps on a write
    function automatic logic [DW-1:0] keep_mask(input int idx);
        logic [DW-1:0] m;
        case (idx)
            IDX_CTRL:                     m = ~(DW'(1) << INVAL_BIT);
            IDX_PGAS:                     m = DW'(32'h0000_000F);
            IDX_TRAP, IDX_EXEV, IDX_INEV: m = DW'(32'h0000_07FF);
            default:                      m = '1;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/mrf_decode.sv
// Address and size decode. Produces a one-hot register select for a good
// access and a flag for a bad one. Assumes byte offsets and word registers.
module mrf_decode #(
    parameter int ADDR_W = 8,
    parameter int NREG   = 9
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic [NREG-1:0]   sel_onehot,
    output logic              acc_bad
);
    import mrf_pkg::*;
    localparam int IW = ADDR_W - 2;

    logic [IW-1:0] word_idx;
    logic          acc_ok;

    assign word_idx = req_addr[ADDR_W-1:2];

    // A good access is word sized, aligned and lands on a mapped register
    always_comb begin
        acc_ok  = req_valid && (req_size == SZ_WORD) && (req_addr[1:0] == 2'b00)
                  && (word_idx < IW'(NREG));
        acc_bad = req_valid && !acc_ok;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel_onehot[g] = acc_ok && (word_idx == IW'(g));
    end
endmodule

// File: rtl/mrf_bank.sv
// Register storage. Each register applies its own keep mask when written.
// Assumes at most one write enable is high per cycle.
module mrf_bank #(
    parameter int NREG = 9,
    parameter int DW   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          wr_en,
    input  logic [DW-1:0]            wdata,
    output logic [NREG-1:0][DW-1:0]  regs_q
);
    import mrf_pkg::*;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] KEEP = keep_mask(g);
        // Store the masked write value, zero on reset
        always_ff @(posedge clk) begin
            if (!rst_n)        regs_q[g] <= '0;
            else if (wr_en[g]) regs_q[g] <= wdata & KEEP;
        end
    end
endmodule

// File: rtl/mrf_strobe.sv
// Strobe generator toward the translation buffer: invalidate-all on a
// control write carrying the invalidate bit, flush on an identifier change.
// Assumes cur_asid is the value held before the current write.
module mrf_strobe #(
    parameter int DW     = 32,
    parameter int ASID_W = 8,
    parameter int IBIT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              pghi_wr,
    input  logic [DW-1:0]     wdata,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              inval_pulse,
    output logic              flush_pulse
);
    // Register both strobes for one cycle after the triggering write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inval_pulse <= 1'b0;
            flush_pulse <= 1'b0;
        end else begin
            inval_pulse <= ctrl_wr && wdata[IBIT];
            flush_pulse <= pghi_wr && (wdata[ASID_W-1:0] != cur_asid);
        end
    end

    // A flush implies the identifier it was compared against has changed
    p_flush_asid_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> (cur_asid != $past(cur_asid)));

    // An invalidate strobe follows a control write
    p_inval_after_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        inval_pulse |-> $past(ctrl_wr));
endmodule

// File: rtl/mmu_ctrl_regfile.sv
// MMU control register file top: decode, masked storage, strobes and a
// registered read path with a sticky error flag. Assumes one access per
// cycle and a synchronous active-low reset.
module mmu_ctrl_regfile #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              err_flag,
    output logic              tlb_inval_pulse,
    output logic              tlb_flush_pulse
);
    import mrf_pkg::*;

    logic [NREG-1:0]         sel_onehot;
    logic                    acc_bad;
    logic [NREG-1:0]         wr_en;
    logic [NREG-1:0][DW-1:0] regs_q;
    logic [DW-1:0]           rd_mux;

    mrf_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) dec_i (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .sel_onehot(sel_onehot),
        .acc_bad   (acc_bad)
    );

    assign wr_en = sel_onehot & {NREG{req_write}};

    mrf_bank #(.NREG(NREG), .DW(DW)) bank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wdata (req_wdata),
        .regs_q(regs_q)
    );

    mrf_strobe #(.DW(DW), .ASID_W(ASID_W), .IBIT(INVAL_BIT)) strb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (wr_en[IDX_CTRL]),
        .pghi_wr    (wr_en[IDX_PGHI]),
        .wdata      (req_wdata),
        .cur_asid   (regs_q[IDX_PGHI][ASID_W-1:0]),
        .inval_pulse(tlb_inval_pulse),
        .flush_pulse(tlb_flush_pulse)
    );

    // AND-OR read multiplexer; zero when nothing is selected
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NREG; i++)
            if (sel_onehot[i]) rd_mux = rd_mux | regs_q[i];
    end

    // Registered read response and sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            err_flag  <= 1'b0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
            err_flag  <= err_flag || acc_bad;
        end
    end

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_bad_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(acc_bad)) |-> (rsp_rdata == '0));

    p_rsp_follows_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    p_ctrl_inval_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(sel_onehot[IDX_CTRL])) |-> !rsp_rdata[INVAL_BIT]);

    p_event_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(sel_onehot[IDX_TRAP] || sel_onehot[IDX_EXEV]
                            || sel_onehot[IDX_INEV])) |-> (rsp_rdata[31:11] == '0));
endmodule

// File: tb/mmu_ctrl_regfile_tb_top.sv
// Self-checking bench: pattern sweep over every mapped register with a
// bench-side model of masks and strobes, then bad-access cases.
module mmu_ctrl_regfile_tb_top;
    localparam int AW = 8;
    localparam int NR = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'b10;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          err_flag;
    logic          tlb_inval_pulse;
    logic          tlb_flush_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] model [NR];
    logic        got_inval, got_flush;
    logic [31:0] got_rd;
    logic        got_rv;

    always #10 clk = ~clk;

    mmu_ctrl_regfile #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_flag(err_flag),
        .tlb_inval_pulse(tlb_inval_pulse), .tlb_flush_pulse(tlb_flush_pulse)
    );

    function automatic logic [31:0] mask_of(input int idx);
        case (idx)
            0:       return 32'hFFFF_FFFB;
            3:       return 32'h0000_000F;
            6, 7, 8: return 32'h0000_07FF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic string req_of(input int idx);
        case (idx)
            0:       return "R2";
            1:       return "R3";
            3:       return "R4";
            6, 7, 8: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One-cycle access; called and returning at a falling edge
    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [1:0] sz,
                          input logic [31:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        got_inval = tlb_inval_pulse;
        got_flush = tlb_flush_pulse;
        got_rd    = rsp_rdata;
        got_rv    = rsp_valid;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic readback_all(input string why);
        for (int i = 0; i < NR; i++) begin
            access(1'b0, AW'(i * 4), 2'b10, 32'h0);
            check({why, " R7 rsp_valid"}, {31'h0, got_rv}, 32'h1);
            check({why, " ", req_of(i), " readback"}, got_rd, model[i]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] pats [7];
        pats = '{32'hFFFF_FFFF, 32'hFFFF_FF00, 32'h1234_5600, 32'hA5A5_A5A5,
                 32'h5A5A_5A5A, 32'h0000_0004, 32'h0000_0000};
        for (int i = 0; i < NR; i++) model[i] = 32'h0;

        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 err_flag in reset", {31'h0, err_flag}, 32'h0);
        check("R9 strobes in reset", {30'h0, tlb_inval_pulse, tlb_flush_pulse}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        readback_all("R9 reset");

        // R7: a write raises no read response
        access(1'b1, 8'h10, 2'b10, 32'h0);
        check("R7 write no rsp", {31'h0, got_rv}, 32'h0);

        // Pattern sweep over every register
        for (int p = 0; p < 7; p++) begin
            for (int i = 0; i < NR; i++) begin
                logic exp_inv, exp_fl;
                exp_inv = (i == 0) && pats[p][2];
                exp_fl  = (i == 1) && (pats[p][7:0] != model[1][7:0]);
                access(1'b1, AW'(i * 4), 2'b10, pats[p]);
                check("R1 invalidate strobe", {31'h0, got_inval}, {31'h0, exp_inv});
                check("R3 flush strobe", {31'h0, got_flush}, {31'h0, exp_fl});
                model[i] = pats[p] & mask_of(i);
                access(1'b0, AW'(i * 4), 2'b10, 32'h0);
                check({req_of(i), " R7 read after write"}, got_rd, model[i]);
            end
        end
        check("R8 no error on good accesses", {31'h0, err_flag}, 32'h0);

        // Put distinct values back before the bad-access cases
        for (int i = 0; i < NR; i++) begin
            access(1'b1, AW'(i * 4), 2'b10, 32'hC3C3_C3C3 ^ i);
            model[i] = (32'hC3C3_C3C3 ^ i) & mask_of(i);
        end

        // R8: unmapped write
        access(1'b1, 8'h24, 2'b10, 32'hFFFF_FFFF);
        check("R8 unmapped write strobes", {30'h0, got_inval, got_flush}, 32'h0);
        check("R8 err set", {31'h0, err_flag}, 32'h1);
        // R8: narrow control write with invalidate bit, and narrow entry-high write
        access(1'b1, 8'h00, 2'b01, 32'h0000_0004);
        check("R8 half write no invalidate", {31'h0, got_inval}, 32'h0);
        access(1'b1, 8'h04, 2'b00, 32'h0000_00EE);
        check("R8 byte write no flush", {31'h0, got_flush}, 32'h0);
        // R8: misaligned write
        access(1'b1, 8'h05, 2'b10, 32'h0000_0077);
        check("R8 misaligned write no flush", {31'h0, got_flush}, 32'h0);
        readback_all("R8 after bad writes");
        // R8: bad reads return zero
        access(1'b0, 8'h28, 2'b10, 32'h0);
        check("R8 unmapped read zero", got_rd, 32'h0);
        access(1'b0, 8'h10, 2'b00, 32'h0);
        check("R8 byte read zero", got_rd, 32'h0);
        access(1'b0, 8'h12, 2'b10, 32'h0);
        check("R8 misaligned read zero", got_rd, 32'h0);
        access(1'b0, 8'hFC, 2'b10, 32'h0);
        check("R8 top offset read zero", got_rd, 32'h0);
        check("R8 err still set", {31'h0, err_flag}, 32'h1);

        // R3: same identifier, different upper bits gives no flush
        access(1'b1, 8'h04, 2'b10, {24'h0, model[1][7:0]});
        check("R3 same asid no flush", {31'h0, got_flush}, 32'h0);
        model[1] = {24'h0, model[1][7:0]};
        access(1'b1, 8'h04, 2'b10, 32'h0000_0001 ^ model[1]);
        check("R3 changed asid flush", {31'h0, got_flush}, 32'h1);
        check("R8 err sticky after good accesses", {31'h0, err_flag}, 32'h1);

        // R9: reset again clears the flag and the registers
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 err cleared by reset", {31'h0, err_flag}, 32'h0);
        for (int i = 0; i < NR; i++) model[i] = 32'h0;
        readback_all("R9 second reset");

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule